// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital controller of a 10-bit successive-approximation converter with 16 analog channels. It selects a channel, presents a trial code to the external DAC and samples a one-bit comparator on each bit decision, working from the most significant bit down. It converts one channel, or scans all channels once or continuously. In comparator mode it makes a single compare against a supplied reference code.

A run starts from a software start bit, a one-cycle hardware event strobe or a falling edge on an external trigger pin. Each channel keeps its last result, which can be read at full width or as an 8-bit value. An interrupt pulse, and a DMA request pulse if that option is built in, mark the end of every completed job.

Top module: `sar_seq`

## Requirements
- R1: During the first sample cycles of a conversion (19 at normal rate, 13 at double rate) `dac_code` is 0. The first trial is 0x200. After that each trial keeps the bits already decided and sets the next lower bit. A bit is kept when `cmp_in` is 1, which means the input is at or above `dac_code`. The stored result is the final decided code.
- R2: A conversion keeps `busy` high for exactly 299 cycles at normal rate (`cfg_dbl`=0) and 173 cycles at double rate (`cfg_dbl`=1).
- R3: Comparator mode (`cfg_cmp`=1 with `cfg_scan`=0) keeps `busy` high for 47 or 29 cycles and drives `cfg_ref` on `dac_code` during the decision. `cmp_result` becomes 1 when the input is at or above the reference and 0 otherwise, and stays stable until the next compare. No stored result changes.
- R4: Single mode converts channel `cfg_ch` on `ch_sel` and stores the result under that channel index. Stored results change only when a conversion completes.
- R5: A single-shot scan (`cfg_scan`=1, `cfg_cont`=0) converts channels 0 to 15 in order and back to back, with `busy` held high throughout, and then stops. `cfg_cmp` is ignored in scan mode.
- R6: A continuous scan (`cfg_cont`=1) wraps from channel 15 to channel 0. If `sw_start` is low when a channel finishes, the scan stops after that channel.
- R7: A rising edge of `sw_start` or a high `hw_evt` starts a run at the next clock edge. A falling edge on `ext_trig_n` passes a two-flop synchroniser, and `busy` is first seen high after the third rising edge that follows the pin change.
- R8: A start request from any source is ignored while `busy` is high.
- R9: With `rd_wide`=1, `rd_data` is the 10-bit result of channel `rd_ch`. With `rd_wide`=0 it is the upper 8 bits of that result in bits 7:0, and bits 9:8 are 0.
- R10: `irq` is a one-cycle pulse in the cycle after a job completes. A job is a single conversion, a compare, a single-shot scan, or one full pass of a continuous scan. When a run ends, `busy` falls in that same cycle.
- R11: With `DMA_EN`=1, `dma_req` equals `irq`. With `DMA_EN`=0, `dma_req` is always 0.
- R12: After reset, `busy`, `irq`, `dma_req`, `cmp_result` and `ch_sel` are 0 and every stored result reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cmp | input | 1 | Comparator mode select (single mode only) |
| cfg_scan | input | 1 | 1 = scan all channels, 0 = single channel |
| cfg_cont | input | 1 | Continuous scan when scanning |
| cfg_dbl | input | 1 | Double-rate timing |
| cfg_ch | input | 4 | Channel for single mode |
| cfg_ref | input | 10 | Reference code for comparator mode |
| sw_start | input | 1 | Software start bit (level; a rising edge starts, low stops a continuous scan) |
| hw_evt | input | 1 | Hardware start strobe |
| ext_trig_n | input | 1 | Asynchronous external trigger, falling-edge active |
| cmp_in | input | 1 | Comparator output, 1 = input at or above `dac_code` |
| ch_sel | output | 4 | Analog channel select |
| dac_code | output | 10 | Trial code to the DAC |
| busy | output | 1 | Run in progress |
| cmp_result | output | 1 | Last comparator-mode outcome |
| irq | output | 1 | Completion interrupt pulse |
| dma_req | output | 1 | Completion DMA request pulse |
| rd_ch | input | 4 | Result read channel |
| rd_wide | input | 1 | 1 = 10-bit read, 0 = 8-bit read |
| rd_data | output | 10 | Result read data |

## Verification
The hardest case to reach is stopping a continuous scan partway through a pass. The bench must clear `sw_start` inside the channel that follows a pass-end pulse. It then checks that the scan stops at that channel's end and that no further interrupt is raised. The bench waits for the second pass pulse and drops the bit in that same cycle. Start requests that arrive while a run is in progress are hard to observe, so the bench sends strobes in the middle of a conversion and checks that the busy length does not change. The bench models the analog inputs as per-channel values and answers the comparator from the live `dac_code`. The bit-by-bit trials are therefore checked against the model values.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  // Operation settings captured when a run is accepted.
  typedef struct packed {
    logic cmp;
    logic scan;
    logic cont;
    logic dbl;
  } sar_op_t;
endpackage

// File: rtl/sar_start_detect.sv
module sar_start_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_start,
  input  logic hw_evt,
  input  logic ext_trig_n,
  output logic start_req
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] pin_q;
  logic              sw_q;
  logic              pin_fall;
  logic              sw_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= '1;
      sw_q  <= 1'b0;
    end else begin
      pin_q <= {pin_q[PIPE_W-2:0], ext_trig_n};
      sw_q  <= sw_start;
    end
  end

  always_comb begin
    pin_fall  = pin_q[PIPE_W-1] & ~pin_q[PIPE_W-2];
    sw_rise   = sw_start & ~sw_q;
    start_req = pin_fall | sw_rise | hw_evt;
  end
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int NBITS = 10,
  parameter int SMP_N = 19,
  parameter int BIT_N = 28,
  parameter int SMP_D = 13,
  parameter int BIT_D = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             active,
  input  logic             dbl,
  input  logic             cmp_mode,
  input  logic [NBITS-1:0] ref_code,
  input  logic             cmp_in,
  output logic [NBITS-1:0] dac_code,
  output logic [NBITS-1:0] final_code,
  output logic             done
);
  localparam int MAX_A  = (SMP_N > BIT_N) ? SMP_N : BIT_N;
  localparam int MAX_B  = (SMP_D > BIT_D) ? SMP_D : BIT_D;
  localparam int MAXLEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int SUB_W  = (MAXLEN > 1) ? $clog2(MAXLEN) : 1;
  localparam int K_W    = (NBITS > 1) ? $clog2(NBITS) : 1;

  logic             in_smp;
  logic [SUB_W-1:0] sub;
  logic [K_W-1:0]   k;
  logic [NBITS-1:0] acc;
  logic [NBITS-1:0] mask;
  logic [SUB_W-1:0] smp_last;
  logic [SUB_W-1:0] bit_last;
  logic             slot_end;
  logic             last_slot;

  always_comb begin
    smp_last   = dbl ? SUB_W'(SMP_D - 1) : SUB_W'(SMP_N - 1);
    bit_last   = dbl ? SUB_W'(BIT_D - 1) : SUB_W'(BIT_N - 1);
    mask       = {1'b1, {(NBITS-1){1'b0}}} >> k;
    slot_end   = (sub == bit_last);
    last_slot  = cmp_mode | (k == K_W'(NBITS - 1));
    done       = active & ~in_smp & slot_end & last_slot;
    final_code = acc | (cmp_in ? mask : '0);
    if (!active || in_smp) begin
      dac_code = '0;
    end else if (cmp_mode) begin
      dac_code = ref_code;
    end else begin
      dac_code = acc | mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_smp <= 1'b1;
      sub    <= '0;
      k      <= '0;
      acc    <= '0;
    end else if (go) begin
      in_smp <= 1'b1;
      sub    <= '0;
      k      <= '0;
      acc    <= '0;
    end else if (active) begin
      if (in_smp) begin
        if (sub == smp_last) begin
          in_smp <= 1'b0;
          sub    <= '0;
        end else begin
          sub <= sub + SUB_W'(1);
        end
      end else if (slot_end) begin
        sub <= '0;
        if (cmp_in) acc <= acc | mask;
        if (!last_slot) k <= k + K_W'(1);
      end else begin
        sub <= sub + SUB_W'(1);
      end
    end
  end
endmodule

// File: rtl/sar_result_bank.sv
module sar_result_bank #(
  parameter int NCH    = 16,
  parameter int NBITS  = 10,
  parameter int NARROW = 8,
  parameter int CH_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_ch,
  input  logic [NBITS-1:0] wr_data,
  input  logic [CH_W-1:0]  rd_ch,
  input  logic             rd_wide,
  output logic [NBITS-1:0] rd_data
);
  logic [NBITS-1:0] mem [NCH];
  logic [NBITS-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_ch] <= wr_data;
    end
  end

  always_comb begin
    word = mem[rd_ch];
  end

  generate
    if (NARROW < NBITS) begin : g_narrow
      assign rd_data = rd_wide ? word
                               : {{(NBITS-NARROW){1'b0}}, word[NBITS-1 -: NARROW]};
    end else begin : g_full
      assign rd_data = word;
    end
  endgenerate
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int NBITS  = 10,
  parameter int NARROW = 8,
  parameter int SMP_N  = 19,
  parameter int BIT_N  = 28,
  parameter int SMP_D  = 13,
  parameter int BIT_D  = 16,
  parameter bit DMA_EN = 1'b1,
  localparam int CH_W  = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_cmp,
  input  logic             cfg_scan,
  input  logic             cfg_cont,
  input  logic             cfg_dbl,
  input  logic [CH_W-1:0]  cfg_ch,
  input  logic [NBITS-1:0] cfg_ref,
  input  logic             sw_start,
  input  logic             hw_evt,
  input  logic             ext_trig_n,
  input  logic             cmp_in,
  output logic [CH_W-1:0]  ch_sel,
  output logic [NBITS-1:0] dac_code,
  output logic             busy,
  output logic             cmp_result,
  output logic             irq,
  output logic             dma_req,
  input  logic [CH_W-1:0]  rd_ch,
  input  logic             rd_wide,
  output logic [NBITS-1:0] rd_data
);
  sar_op_t          op;
  logic [CH_W-1:0]  ch;
  logic [NBITS-1:0] ref_q;
  logic [NBITS-1:0] final_code;
  logic             busy_q;
  logic             irq_q;
  logic             cmpr_q;
  logic             start_req;
  logic             accept;
  logic             done;
  logic             last_ch;
  logic             keep;
  logic             go;

  sar_start_detect #(.SYNC_STAGES(2)) u_start (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_start   (sw_start),
    .hw_evt     (hw_evt),
    .ext_trig_n (ext_trig_n),
    .start_req  (start_req)
  );

  always_comb begin
    last_ch = (ch == CH_W'(NCH - 1));
    keep    = op.scan & (~last_ch | op.cont) & ~(op.cont & ~sw_start);
    accept  = start_req & ~busy_q;
    go      = accept | (done & keep);
  end

  sar_bit_engine #(
    .NBITS (NBITS),
    .SMP_N (SMP_N),
    .BIT_N (BIT_N),
    .SMP_D (SMP_D),
    .BIT_D (BIT_D)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .active     (busy_q),
    .dbl        (op.dbl),
    .cmp_mode   (op.cmp),
    .ref_code   (ref_q),
    .cmp_in     (cmp_in),
    .dac_code   (dac_code),
    .final_code (final_code),
    .done       (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op     <= '0;
      ch     <= '0;
      ref_q  <= '0;
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
      cmpr_q <= 1'b0;
    end else begin
      irq_q <= done & (~op.scan | last_ch);
      if (accept) begin
        busy_q   <= 1'b1;
        op.cmp   <= cfg_cmp & ~cfg_scan;
        op.scan  <= cfg_scan;
        op.cont  <= cfg_cont;
        op.dbl   <= cfg_dbl;
        ch       <= cfg_scan ? '0 : cfg_ch;
        ref_q    <= cfg_ref;
      end else if (done) begin
        busy_q <= keep;
        if (keep) ch <= last_ch ? '0 : ch + CH_W'(1);
        if (op.cmp) cmpr_q <= cmp_in;
      end
    end
  end

  sar_result_bank #(
    .NCH    (NCH),
    .NBITS  (NBITS),
    .NARROW (NARROW),
    .CH_W   (CH_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (done & ~op.cmp),
    .wr_ch   (ch),
    .wr_data (final_code),
    .rd_ch   (rd_ch),
    .rd_wide (rd_wide),
    .rd_data (rd_data)
  );

  assign ch_sel     = ch;
  assign busy       = busy_q;
  assign irq        = irq_q;
  assign cmp_result = cmpr_q;

  generate
    if (DMA_EN) begin : g_dma
      assign dma_req = irq_q;
    end else begin : g_no_dma
      assign dma_req = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int NBITS = 10,
  parameter int CH_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             irq,
  input logic             dma_req,
  input logic             cmp_result,
  input logic [NBITS-1:0] dac_code,
  input logic [CH_W-1:0]  rd_ch,
  input logic             rd_wide,
  input logic [NBITS-1:0] rd_data
);
  AST_SAMPLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> dac_code == '0); // R1

  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(cmp_result)); // R3

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy ##1 ($stable(rd_ch) && $stable(rd_wide))) |-> $stable(rd_data)); // R4

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R10

  AST_IRQ_AFTER_OP: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(busy)); // R10

  AST_DMA_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> irq); // R11
endmodule

bind sar_seq sar_seq_chk #(.NBITS(NBITS), .CH_W(CH_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .irq        (irq),
  .dma_req    (dma_req),
  .cmp_result (cmp_result),
  .dac_code   (dac_code),
  .rd_ch      (rd_ch),
  .rd_wide    (rd_wide),
  .rd_data    (rd_data)
);

// File: tb/test_sar_seq.sv
module test_sar_seq;
  localparam int NCH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_cmp = 1'b0, cfg_scan = 1'b0, cfg_cont = 1'b0, cfg_dbl = 1'b0;
  logic [3:0] cfg_ch = '0;
  logic [9:0] cfg_ref = '0;
  logic       sw_start = 1'b0, hw_evt = 1'b0, ext_trig_n = 1'b1;
  logic       cmp_in;
  logic [3:0] ch_sel;
  logic [9:0] dac_code;
  logic       busy, cmp_result, irq, dma_req;
  logic [3:0] rd_ch = '0;
  logic       rd_wide = 1'b1;
  logic [9:0] rd_data;

  int ain [NCH];
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  assign cmp_in = (ain[ch_sel] >= int'(dac_code));

  sar_seq i_sar_seq (
    .clk(clk), .rst_n(rst_n), .cfg_cmp(cfg_cmp), .cfg_scan(cfg_scan),
    .cfg_cont(cfg_cont), .cfg_dbl(cfg_dbl), .cfg_ch(cfg_ch), .cfg_ref(cfg_ref),
    .sw_start(sw_start), .hw_evt(hw_evt), .ext_trig_n(ext_trig_n), .cmp_in(cmp_in),
    .ch_sel(ch_sel), .dac_code(dac_code), .busy(busy), .cmp_result(cmp_result),
    .irq(irq), .dma_req(dma_req), .rd_ch(rd_ch), .rd_wide(rd_wide), .rd_data(rd_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge.
  int m_busy, m_cnt, m_len, m_ch, m_cmp, m_scan, m_cont, m_dbl, m_ref, m_irq, m_cmpr;
  int m_res [NCH];
  int p1, p2, p3, swp;
  int fall, st, nirq;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_len = 0; m_ch = 0; m_cmp = 0; m_scan = 0;
      m_cont = 0; m_dbl = 0; m_ref = 0; m_irq = 0; m_cmpr = 0;
      foreach (m_res[i]) m_res[i] = 0;
      p1 = 1; p2 = 1; p3 = 1; swp = 0;
    end else begin
      fall = (p3 == 1 && p2 == 0) ? 1 : 0;
      p3 = p2; p2 = p1; p1 = int'(ext_trig_n);
      st = ((sw_start && swp == 0) || hw_evt || fall) ? 1 : 0;
      swp = int'(sw_start);
      nirq = 0;
      if (m_busy != 0) begin
        m_cnt++;
        if (m_cnt == m_len) begin
          if (m_cmp != 0) m_cmpr = (ain[m_ch] >= m_ref) ? 1 : 0;
          else m_res[m_ch] = ain[m_ch];
          nirq = (m_scan == 0 || m_ch == NCH - 1) ? 1 : 0;
          if (m_scan != 0 && (m_ch != NCH - 1 || m_cont != 0) && !(m_cont != 0 && !sw_start)) begin
            m_ch = (m_ch + 1) % NCH;
            m_cnt = 0;
          end else begin
            m_busy = 0;
          end
        end
      end else if (st != 0) begin
        m_busy = 1; m_cnt = 0;
        m_scan = int'(cfg_scan); m_cont = int'(cfg_cont); m_dbl = int'(cfg_dbl);
        m_cmp = (cfg_cmp && !cfg_scan) ? 1 : 0;
        m_ref = int'(cfg_ref);
        m_ch = cfg_scan ? 0 : int'(cfg_ch);
        if (m_cmp != 0) m_len = (m_dbl != 0) ? 29 : 47;
        else m_len = (m_dbl != 0) ? 173 : 299;
      end
      m_irq = nirq;
    end
  end

  // Per-cycle comparison, away from the active edge.
  int cur_len = 0, last_len = 0, irq_cnt = 0;
  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      int smp;
      int w;
      chk("R2 busy", int'(busy), m_busy);
      chk("R5 ch_sel", int'(ch_sel), m_ch);
      chk("R10 irq", int'(irq), m_irq);
      chk("R11 dma_req", int'(dma_req), m_irq);
      chk("R3 cmp_result", int'(cmp_result), m_cmpr);
      w = m_res[rd_ch];
      chk("R9 rd_data", int'(rd_data), rd_wide ? w : (w >> 2));
      if (m_busy != 0) begin
        smp = (m_dbl != 0) ? 13 : 19;
        if (m_cnt < smp) chk("R1 sample code", int'(dac_code), 0);
        else if (m_cnt == smp) chk("R1 first trial", int'(dac_code), (m_cmp != 0) ? m_ref : 512);
        if (m_cmp == 0 && m_cnt == m_len - 1)
          chk("R1 last trial", int'(dac_code), (ain[m_ch] & 1022) | 1);
      end
      if (busy) cur_len++;
      else if (cur_len != 0) begin
        last_len = cur_len;
        cur_len = 0;
      end
      if (irq) irq_cnt++;
    end
  end

  task automatic pulse_sw();
    @(negedge clk) sw_start = 1'b1;
    @(negedge clk) sw_start = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk); #4;
    while (busy) begin
      @(negedge clk); #4;
    end
  endtask

  task automatic read_chk(input string req, input int ch, input bit wide, input int exp);
    @(negedge clk) begin rd_ch = 4'(ch); rd_wide = wide; end
    #4 chk(req, int'(rd_data), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int base;
    for (int i = 0; i < NCH; i++) ain[i] = (i * 67 + 5) % 1024;
    ain[3] = 1023; ain[5] = 0; ain[7] = 512;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #4;
    // R12 reset state
    chk("R12 busy", int'(busy), 0);
    chk("R12 irq", int'(irq), 0);
    chk("R12 dma_req", int'(dma_req), 0);
    chk("R12 ch_sel", int'(ch_sel), 0);
    chk("R12 cmp_result", int'(cmp_result), 0);
    chk("R12 result", int'(rd_data), 0);

    // R4 single conversion, normal rate, software start
    cfg_ch = 4'd3;
    pulse_sw();
    wait_idle();
    chk("R2 normal length", last_len, 299);
    read_chk("R4 result ch3", 3, 1'b1, 1023);
    read_chk("R9 narrow ch3", 3, 1'b0, 255);

    // R7 hardware strobe, double rate; R8 ignored starts mid-run
    cfg_ch = 4'd5; cfg_dbl = 1'b1;
    @(negedge clk) hw_evt = 1'b1;
    @(negedge clk) hw_evt = 1'b0;
    repeat (50) @(negedge clk);
    hw_evt = 1'b1;
    @(negedge clk) begin hw_evt = 1'b0; sw_start = 1'b1; end
    @(negedge clk) sw_start = 1'b0;
    wait_idle();
    chk("R8 start while busy ignored", last_len, 173);
    read_chk("R1 zero input ch5", 5, 1'b1, 0);

    // R3 comparator, external pin start; R7 synchroniser latency
    cfg_cmp = 1'b1; cfg_dbl = 1'b0; cfg_ch = 4'd7; cfg_ref = 10'd500;
    @(negedge clk) ext_trig_n = 1'b0;
    @(negedge clk); #4 chk("R7 pin stage 1", int'(busy), 0);
    @(negedge clk); #4 chk("R7 pin stage 2", int'(busy), 0);
    @(negedge clk); #4 chk("R7 pin start", int'(busy), 1);
    @(negedge clk) ext_trig_n = 1'b1;
    wait_idle();
    chk("R3 compare length normal", last_len, 47);
    chk("R3 above reference", int'(cmp_result), 1);
    read_chk("R3 no store ch7", 7, 1'b1, 0);
    cfg_dbl = 1'b1; cfg_ref = 10'd600;
    pulse_sw();
    wait_idle();
    chk("R3 compare length double", last_len, 29);
    chk("R3 below reference", int'(cmp_result), 0);

    // R5 single-shot scan, comparator select ignored
    cfg_scan = 1'b1; cfg_cont = 1'b0; cfg_dbl = 1'b0;
    base = irq_cnt;
    pulse_sw();
    wait_idle();
    chk("R5 scan length", last_len, 16 * 299);
    chk("R10 one pulse per single-shot scan", irq_cnt - base, 1);
    for (int i = 0; i < NCH; i++) read_chk("R5 scan result", i, 1'b1, ain[i]);
    read_chk("R9 narrow ch7", 7, 1'b0, 128);

    // R6 continuous scan stopped by clearing the start bit
    for (int i = 0; i < NCH; i++) ain[i] = 1023 - ain[i];
    cfg_cmp = 1'b0; cfg_cont = 1'b1; cfg_dbl = 1'b1;
    base = irq_cnt;
    @(negedge clk) sw_start = 1'b1;
    while (irq_cnt < base + 2) begin
      @(negedge clk); #4;
    end
    sw_start = 1'b0;
    wait_idle();
    chk("R6 stop after current channel", last_len, 33 * 173);
    chk("R6 pulses per pass", irq_cnt - base, 2);
    chk("R6 stopped channel", int'(ch_sel), 0);
    for (int i = 0; i < NCH; i++) read_chk("R6 scan result", i, 1'b1, ain[i]);

    repeat (5) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule